// File: doc/BRIEF.md
# Credential Table with Sequential Search-and-Remove

This block keeps a small on-chip table of fixed-width credential words. A slot that holds all ones is empty. A remove request gives a credential value. The block then walks the table one slot per clock, starting at the lowest index. It overwrites the first slot that holds that value with the all-ones empty marker. When the walk ends, it gives a one-cycle completion pulse with a found flag.

The search is a bounded, clocked walk and not a combinational loop, so the worst-case time is fixed by the table depth. A direct load port and a debug read port let a test environment fill and inspect the table. While a walk is running, the block reports busy and ignores new remove requests.

Top module: `cred_purge_table`

## Requirements
- R1: After reset, every slot reads as all ones (24'hFFFFFF at default width), and busy, done and found are low.
- R2: A load pulse (load_en high at a rising edge) with load_index below DEPTH writes load_value into that slot, and the read port returns it from the next cycle. Loads to an index of DEPTH or more change nothing. A read at such an index returns all ones.
- R3: A remove pulse sampled while idle makes busy high from the next cycle. The walk starts at index 0 and moves up by one slot per clock. When several slots hold the value, the lowest-indexed one is removed first.
- R4: If the first matching slot is index k, done and found are both high in the cycle that follows k+1 rising edges after the accepting edge. That slot then reads as all ones, and every other slot is unchanged.
- R5: If no slot matches, done is high with found low after DEPTH rising edges from the accepting edge, and the table is left unchanged.
- R6: done lasts exactly one cycle, busy is low while done is high, and found is never high without done.
- R7: A remove pulse that arrives while busy is high is ignored. It neither restarts the walk nor clears any slot.
- R8: A request for the all-ones value is never reported as found. It ends after the full DEPTH cycles with found low.
- R9: If a load and a removal clear hit the same slot at the same edge, the clear wins and the slot reads all ones.
- R10: Asserting the active-high reset during a walk drops busy at once without waiting for a clock edge. No done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high reset |
| load_en | input | 1 | Write load_value into slot load_index |
| load_index | input | IDX_W (7) | Slot selected for a load |
| load_value | input | WIDTH (24) | Credential word to store |
| rm_en | input | 1 | Remove request, sampled only when idle |
| rm_value | input | WIDTH (24) | Credential to search for and remove |
| rd_index | input | IDX_W (7) | Slot shown on rd_value |
| rd_value | output | WIDTH (24) | Combinational contents of slot rd_index |
| busy | output | 1 | High while a walk is in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | High with done when a slot was cleared |

## Verification
The two functions that can meet in one cycle are a table load and the clear that ends a successful walk, both aimed at the same slot. The bench starts a removal of the value held in slot 3. It counts three clock edges after the accepting edge and then drives a load to slot 3, so the load and the clear land on the same edge. It then judges that done and found are high and that slot 3 reads all ones, not the loaded value. A second case overlaps a remove request with a running walk and checks that the slot named by the ignored request still holds its value.

// File: rtl/cpt_pkg.sv
package cpt_pkg;
   localparam int DEF_WIDTH = 24;
   localparam int DEF_DEPTH = 100;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WALK = 1'b1
   } walk_state_t;
endpackage

// File: rtl/cpt_entry_bank.sv
module cpt_entry_bank #(
   parameter int WIDTH = 24,
   parameter int DEPTH = 100,
   parameter int IDX_W = 7
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ld_en,
   input  logic [IDX_W-1:0] ld_idx,
   input  logic [WIDTH-1:0] ld_data,
   input  logic             clr_en,
   input  logic [IDX_W-1:0] clr_idx,
   input  logic [IDX_W-1:0] walk_idx,
   output logic [WIDTH-1:0] walk_data,
   input  logic [IDX_W-1:0] dbg_idx,
   output logic [WIDTH-1:0] dbg_data
);
   logic [WIDTH-1:0] slot_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic hit_clr, hit_ld;
      assign hit_clr = clr_en && (clr_idx == IDX_W'(g));
      assign hit_ld  = ld_en  && (ld_idx  == IDX_W'(g));
      always_ff @(posedge clk or posedge rst) begin
         if (rst)          slot_q[g] <= '1;
         else if (hit_clr) slot_q[g] <= '1;
         else if (hit_ld)  slot_q[g] <= ld_data;
      end
   end

   assign walk_data = (walk_idx < IDX_W'(DEPTH)) ? slot_q[walk_idx] : '1;
   assign dbg_data  = (dbg_idx  < IDX_W'(DEPTH)) ? slot_q[dbg_idx]  : '1;

   // R4 / R9: a cleared slot holds the empty marker afterwards, load or not
   a_r4_cleared_slot_empty: assert property (@(posedge clk) disable iff (rst)
      clr_en |=> slot_q[$past(clr_idx)] == {WIDTH{1'b1}});
endmodule

// File: rtl/cpt_walk_ctrl.sv
module cpt_walk_ctrl
   import cpt_pkg::*;
#(
   parameter int WIDTH = 24,
   parameter int DEPTH = 100,
   parameter int IDX_W = 7
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req_en,
   input  logic [WIDTH-1:0] req_key,
   input  logic [WIDTH-1:0] slot_data,
   output logic [IDX_W-1:0] walk_idx,
   output logic             clr_en,
   output logic             busy,
   output logic             done,
   output logic             found
);
   localparam logic [WIDTH-1:0] EMPTY_WORD = '1;
   localparam logic [IDX_W-1:0] LAST_IDX   = IDX_W'(DEPTH - 1);

   walk_state_t      state_q;
   logic [IDX_W-1:0] idx_q;
   logic [WIDTH-1:0] key_q;
   logic             done_q, found_q;
   logic             walking, hit, at_end;

   assign walking = (state_q == ST_WALK);
   assign hit     = walking && (slot_data == key_q) && (key_q != EMPTY_WORD);
   assign at_end  = (idx_q == LAST_IDX);

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         key_q   <= EMPTY_WORD;
         done_q  <= 1'b0;
         found_q <= 1'b0;
      end else begin
         done_q  <= 1'b0;
         found_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (req_en) begin
               key_q   <= req_key;
               idx_q   <= '0;
               state_q <= ST_WALK;
            end
            ST_WALK: if (hit || at_end) begin
               state_q <= ST_IDLE;
               idx_q   <= '0;
               done_q  <= 1'b1;
               found_q <= hit;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign walk_idx = idx_q;
   assign clr_en   = hit;
   assign busy     = walking;
   assign done     = done_q;
   assign found    = found_q;

   a_r6_found_needs_done: assert property (@(posedge clk) disable iff (rst)
      found |-> done);
   a_r6_done_not_busy: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy);
   a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   a_r7_key_held: assert property (@(posedge clk) disable iff (rst)
      (busy && !done) |=> (key_q == $past(key_q)));
   a_r3_idx_in_range: assert property (@(posedge clk) disable iff (rst)
      idx_q <= LAST_IDX);
   a_r8_no_empty_hit: assert property (@(posedge clk) disable iff (rst)
      found |-> (key_q != EMPTY_WORD));
endmodule

// File: rtl/cred_purge_table.sv
module cred_purge_table #(
   parameter  int WIDTH = cpt_pkg::DEF_WIDTH,
   parameter  int DEPTH = cpt_pkg::DEF_DEPTH,
   localparam int IDX_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_en,
   input  logic [IDX_W-1:0] load_index,
   input  logic [WIDTH-1:0] load_value,
   input  logic             rm_en,
   input  logic [WIDTH-1:0] rm_value,
   input  logic [IDX_W-1:0] rd_index,
   output logic [WIDTH-1:0] rd_value,
   output logic             busy,
   output logic             done,
   output logic             found
);
   if (WIDTH < 2) begin : g_bad_width
      $error("cred_purge_table: WIDTH must be at least 2");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("cred_purge_table: DEPTH must be at least 2");
   end

   logic [IDX_W-1:0] walk_idx;
   logic [WIDTH-1:0] walk_data;
   logic             clr_en;

   cpt_walk_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .req_en   (rm_en),
      .req_key  (rm_value),
      .slot_data(walk_data),
      .walk_idx (walk_idx),
      .clr_en   (clr_en),
      .busy     (busy),
      .done     (done),
      .found    (found)
   );

   cpt_entry_bank #(.WIDTH(WIDTH), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .ld_en    (load_en),
      .ld_idx   (load_index),
      .ld_data  (load_value),
      .clr_en   (clr_en),
      .clr_idx  (walk_idx),
      .walk_idx (walk_idx),
      .walk_data(walk_data),
      .dbg_idx  (rd_index),
      .dbg_data (rd_value)
   );

   // R10: reset clears the walk regardless of the clock
   always_comb begin
      if (rst) a_r10_reset_idle: assert (!done && !found);
   end
endmodule

// File: tb/cred_purge_table_tb_top.sv
module cred_purge_table_tb_top;
   localparam int W = 24;
   localparam int D = 100;
   localparam int IW = $clog2(D + 1);
   localparam logic [W-1:0] EMPTY = '1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic load_en = 1'b0;
   logic [IW-1:0] load_index = '0;
   logic [W-1:0] load_value = '0;
   logic rm_en = 1'b0;
   logic [W-1:0] rm_value = '0;
   logic [IW-1:0] rd_index = '0;
   logic [W-1:0] rd_value;
   logic busy, done, found;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   cred_purge_table dut_i (
      .clk(clk), .rst(rst), .load_en(load_en), .load_index(load_index),
      .load_value(load_value), .rm_en(rm_en), .rm_value(rm_value),
      .rd_index(rd_index), .rd_value(rd_value), .busy(busy), .done(done),
      .found(found)
   );

   // vector: {value[23:0], exp_found, latency[7:0], slot[6:0]}
   localparam int NV = 6;
   localparam logic [39:0] VEC [NV] = '{
      {24'h100000, 1'b1, 8'd1,   7'd0},
      {24'h00ABCD, 1'b1, 8'd11,  7'd10},
      {24'h00ABCD, 1'b1, 8'd51,  7'd50},
      {24'h00ABCD, 1'b0, 8'd100, 7'd0},
      {24'h100063, 1'b1, 8'd100, 7'd99},
      {24'hFFFFFF, 1'b0, 8'd100, 7'd0}
   };

   function automatic logic [W-1:0] seed(int i);
      if (i == 10 || i == 50) return 24'h00ABCD;
      return 24'h100000 + W'(i);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(int idx, output logic [W-1:0] v);
      rd_index = IW'(idx);
      #1 v = rd_value;
   endtask

   task automatic load(int idx, logic [W-1:0] v);
      @(negedge clk);
      load_en = 1'b1; load_index = IW'(idx); load_value = v;
      @(negedge clk);
      load_en = 1'b0;
   endtask

   // accept edge, then count edges until done seen after an edge
   task automatic remove(logic [W-1:0] v, output int lat, output logic f);
      @(negedge clk);
      rm_en = 1'b1; rm_value = v;
      @(posedge clk);
      @(negedge clk);
      rm_en = 1'b0;
      chk("R3 busy after accept", 32'(busy), 32'd1);
      lat = 0; f = 1'b0;
      while (lat < 200) begin
         @(posedge clk); lat++;
         @(negedge clk);
         if (done) begin f = found; break; end
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : main
      logic [W-1:0] v;
      int lat;
      logic f;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1 reset state
      chk("R1 busy", 32'(busy), 0);
      chk("R1 done", 32'(done), 0);
      chk("R1 found", 32'(found), 0);
      rd(0, v);  chk("R1 slot0", 32'(v), 32'(EMPTY));
      rd(99, v); chk("R1 slot99", 32'(v), 32'(EMPTY));

      for (int i = 0; i < D; i++) load(i, seed(i));
      rd(10, v); chk("R2 load slot10", 32'(v), 32'h00ABCD);
      rd(42, v); chk("R2 load slot42", 32'(v), 32'h10002A);
      load(110, 24'h123456);
      rd(110, v); chk("R2 out-of-range read", 32'(v), 32'(EMPTY));
      rd(99, v);  chk("R2 out-of-range load no effect", 32'(v), 32'h100063);

      // vector walk: R3 R4 R5 R8
      for (int k = 0; k < NV; k++) begin
         remove(VEC[k][39:16], lat, f);
         chk("R4/R5 latency", 32'(lat), 32'(VEC[k][14:7]));
         chk("R4/R5/R8 found", 32'(f), 32'(VEC[k][15]));
         chk("R6 busy low at done", 32'(busy), 0);
         if (VEC[k][15]) begin
            rd(int'(VEC[k][6:0]), v);
            chk("R4 slot cleared", 32'(v), 32'(EMPTY));
         end
         @(negedge clk);
         chk("R6 done one cycle", 32'(done), 0);
      end
      rd(50, v); chk("R3 lowest first then next", 32'(v), 32'(EMPTY));
      rd(11, v); chk("R4 neighbour intact", 32'(v), 32'h10000B);
      rd(49, v); chk("R5 table unchanged", 32'(v), 32'h100031);

      // R7: request during a walk is ignored
      load(99, 24'h777777);
      @(negedge clk);
      rm_en = 1'b1; rm_value = 24'h777777;
      @(negedge clk);
      rm_value = 24'h100005;
      repeat (5) @(negedge clk);
      rm_en = 1'b0;
      lat = 0;
      while (!done && lat < 200) begin @(negedge clk); lat++; end
      chk("R7 original walk found", 32'(found), 1);
      rd(5, v); chk("R7 ignored request no clear", 32'(v), 32'h100005);
      rd(99, v); chk("R7 original slot cleared", 32'(v), 32'(EMPTY));

      // R9: load and clear on the same slot at the same edge
      @(negedge clk);
      rm_en = 1'b1; rm_value = 24'h100003;
      @(posedge clk);
      @(negedge clk); rm_en = 1'b0;
      @(posedge clk); @(posedge clk); @(posedge clk);
      @(negedge clk);
      load_en = 1'b1; load_index = 7'd3; load_value = 24'h5A5A5A;
      @(posedge clk);
      @(negedge clk);
      load_en = 1'b0;
      chk("R9 done", 32'(done), 1);
      chk("R9 found", 32'(found), 1);
      rd(3, v); chk("R9 clear wins", 32'(v), 32'(EMPTY));

      // R10: async reset mid-walk
      @(negedge clk);
      rm_en = 1'b1; rm_value = 24'h00FFEE;
      @(negedge clk); rm_en = 1'b0;
      repeat (4) @(negedge clk);
      #1 rst = 1'b1;
      #1 chk("R10 busy drops at once", 32'(busy), 0);
      @(negedge clk); rst = 1'b0;
      lat = 0;
      for (int i = 0; i < 110; i++) begin @(negedge clk); if (done) lat++; end
      chk("R10 no done after reset", 32'(lat), 0);
      rd(20, v); chk("R10/R1 table emptied", 32'(v), 32'(EMPTY));

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule